// File: doc/BRIEF.md
# ISA Host Bus Cycle Sequencer

This block sits on the host side of a 16-bit ISA-style expansion bus. It turns one internal request into the bus cycles that carry it out. A request names a word address, the access kind (memory or I/O), the direction, two byte enables and the write data. The sequencer then runs the cycle on the bus:

- an address phase with the address-latch strobe;
- a command phase with the matching read or write strobe;
- the default wait states for the access width, adjusted by the slave's ready and no-wait inputs.

During each cycle it watches the slave's 16-bit acknowledge inputs. If a word access is not claimed as 16-bit, it finishes the access as two byte transfers and joins the two halves into one result. It returns read data together with a one-clock done pulse.

The block runs in the bus clock domain. Each clock of `clk` is one bus clock. Sampling points that fall inside a bus clock ("first half", "midpoint") are taken at the rising edge that closes that clock. DMA, refresh and interrupts are not part of this block, so the DMA-owner line is held low at all times.

Top module: `isa_cycle_seq`

## Requirements
- R1: A request is accepted only while `busy` is low. The next clock is one address clock with `bale` high. From the clock after that, exactly one command strobe stays low without a break until the transfer ends. Each transfer has its own address clock. `done` is high for exactly one clock: the clock right after the last strobe clock of the request.
- R2: With `chrdy` high and `nows_n` high, the strobe of a byte (8-bit) transfer is low for WAIT8+1 clocks (5 by default). The strobe of a claimed 16-bit transfer is low for WAIT16+1 clocks (2 by default).
- R3: Each strobe clock in which `chrdy` is sampled low adds one more strobe clock. While `chrdy` is low, `nows_n` is ignored.
- R4: Low `nows_n` with `chrdy` high behaves as follows:
  - a byte transfer ends after its first wait clock (2 strobe clocks);
  - a 16-bit memory transfer ends in its first command clock (1 strobe clock);
  - on a 16-bit I/O transfer it has no effect.
- R5: The strobe is chosen by kind and direction: I/O read `iorc_n`, I/O write `iowc_n`, memory read `mrdc_n`, memory write `mwtc_n`. `aen` stays low throughout.
- R6: `smrdc_n` and `smwtc_n` copy `mrdc_n` and `mwtc_n` clock for clock when address bits 23..20 are all zero. Otherwise they stay high for the whole cycle.
- R7: The byte enables `req_be` (bit 0 is the low byte) set the lanes:
  - `01` (or `00`): SA0=0, `sbhe_n`=1, SD7..0 read into `rd_data[7:0]`;
  - `10`: SA0=1, `sbhe_n`=0, SD15..8 read into `rd_data[15:8]`;
  - `11`: SA0=0, `sbhe_n`=0.
  Lanes of `rd_data` that are not read, and all of `rd_data` after a write, are zero. SA and `sbhe_n` hold steady while the strobe is low.
- R8: A word access counts as claimed 16-bit as follows:
  - I/O: `io16_n` is low at the end of the first command clock;
  - memory: `m16_n` is low at the end of the address clock or at the end of the first command clock.
  `m16_n` is ignored on I/O cycles and `io16_n` is ignored on memory cycles.
- R9: An unclaimed word access becomes two byte transfers, each with byte timing. The first uses SA0=0 and `sbhe_n`=0. The second uses SA0=1 and `sbhe_n`=1 and moves the high byte on SD7..0. `rd_data` holds {second byte, first byte}, and there is a single `done`.
- R10: Read data is taken from `sd_in` at the clock edge that closes the last strobe clock of each transfer.
- R11: During write strobes `sd_oe` is high and `sd_out` carries `req_wdata`. For the second half of a split, it carries the high byte on both lanes. During read strobes `sd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; taken while idle |
| req_waddr | input | ADDR_W-1 | Word address (byte address bits 23..1) |
| req_io | input | 1 | 1 = I/O access, 0 = memory |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 low byte |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Assembled read data |
| bale | output | 1 | Address latch strobe |
| sa | output | SA_W | Latched system address |
| la | output | ADDR_W-SA_W+3 | Upper (unlatched) address lines |
| sbhe_n | output | 1 | High byte enable, active low |
| aen | output | 1 | DMA-owner indication, held low |
| iorc_n | output | 1 | I/O read strobe |
| iowc_n | output | 1 | I/O write strobe |
| mrdc_n | output | 1 | Memory read strobe |
| mwtc_n | output | 1 | Memory write strobe |
| smrdc_n | output | 1 | Memory read strobe below 1 MB |
| smwtc_n | output | 1 | Memory write strobe below 1 MB |
| sd_out | output | 16 | Data driven onto the bus |
| sd_oe | output | 1 | Data drive enable |
| sd_in | input | 16 | Data read from the bus |
| chrdy | input | 1 | Slave ready; low extends the cycle |
| nows_n | input | 1 | Slave no-wait request, active low |
| io16_n | input | 1 | Slave claims 16-bit I/O |
| m16_n | input | 1 | Slave claims 16-bit memory |

## Verification
The properties assume that the slave inputs are synchronous to `clk` and settled before each rising edge. They also assume that requests only arrive while the block is idle. The bench meets both conditions:

- It changes every slave input on the falling edge, based on the strobe and address-latch state seen there.
- It raises `req_valid` for a single clock, and only after the previous `done`.

The bench models a slave whose `chrdy`-low stretch is kept short (at most three clocks per transfer). This keeps every cycle well inside the bench's time limit.

// File: rtl/isa_seq_pkg.sv
`timescale 1ns/1ps
package isa_seq_pkg;
   localparam int unsigned BUS_W = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_CMD  = 2'd2,
      ST_WAIT = 2'd3
   } seq_state_e;

   // an empty enable set is treated as the low byte
   function automatic logic [1:0] norm_be(input logic [1:0] be);
      return (be == 2'b00) ? 2'b01 : be;
   endfunction
endpackage

// File: rtl/isa_width_probe.sv
`timescale 1ns/1ps
module isa_width_probe #(
   parameter bit M16_TWICE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_addr,
   input  logic in_cmd,
   input  logic is_io,
   input  logic io16_n,
   input  logic m16_n,
   output logic ack16
);
   logic m16_early_q;
   logic ack_mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       m16_early_q <= 1'b0;
      else if (in_addr) m16_early_q <= ~m16_n;
   end

   generate
      if (M16_TWICE) begin : g_two_samples
         assign ack_mem = m16_early_q | ~m16_n;
      end else begin : g_one_sample
         assign ack_mem = m16_early_q;
      end
   endgenerate

   assign ack16 = in_cmd & (is_io ? ~io16_n : ack_mem);
endmodule

// File: rtl/isa_wait_ctrl.sv
`timescale 1ns/1ps
module isa_wait_ctrl #(
   parameter int unsigned WAIT8  = 4,
   parameter int unsigned WAIT16 = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_cmd,
   input  logic in_wait,
   input  logic wide,
   input  logic is_io,
   input  logic chrdy,
   input  logic nows_n,
   output logic end_now
);
   localparam int unsigned MAXW  = (WAIT8 > WAIT16) ? WAIT8 : WAIT16;
   localparam int unsigned CNT_W = $clog2(MAXW + 1);
   localparam logic [CNT_W-1:0] L8    = CNT_W'(WAIT8);
   localparam logic [CNT_W-1:0] L16   = CNT_W'(WAIT16);
   localparam logic [CNT_W-1:0] L8M1  = CNT_W'(WAIT8 - 1);
   localparam logic [CNT_W-1:0] L16M1 = CNT_W'(WAIT16 - 1);

   logic [CNT_W-1:0] rem_q, rem_d;

   always_comb begin
      end_now = 1'b0;
      rem_d   = rem_q;
      if (in_cmd) begin
         if (!chrdy)                         rem_d   = wide ? L16 : L8;
         else if (wide && !is_io && !nows_n) end_now = 1'b1;
         else                                rem_d   = wide ? L16M1 : L8M1;
      end else if (in_wait && chrdy) begin
         if (rem_q == '0)                        end_now = 1'b1;
         else if (!(wide && is_io) && !nows_n)   end_now = 1'b1;
         else                                    rem_d   = rem_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rem_q <= '0;
      else        rem_q <= rem_d;
   end
endmodule

// File: rtl/isa_strobe_dec.sv
`timescale 1ns/1ps
module isa_strobe_dec (
   input  logic active,
   input  logic is_io,
   input  logic is_wr,
   input  logic low_meg,
   output logic iorc_n,
   output logic iowc_n,
   output logic mrdc_n,
   output logic mwtc_n,
   output logic smrdc_n,
   output logic smwtc_n
);
   logic mem_rd, mem_wr;
   assign mem_rd  = active & ~is_io & ~is_wr;
   assign mem_wr  = active & ~is_io &  is_wr;
   assign iorc_n  = ~(active & is_io & ~is_wr);
   assign iowc_n  = ~(active & is_io &  is_wr);
   assign mrdc_n  = ~mem_rd;
   assign mwtc_n  = ~mem_wr;
   assign smrdc_n = ~(mem_rd & low_meg);
   assign smwtc_n = ~(mem_wr & low_meg);
endmodule

// File: rtl/isa_cycle_seq.sv
`timescale 1ns/1ps
module isa_cycle_seq
   import isa_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned SA_W      = 20,
   parameter int unsigned WAIT8     = 4,
   parameter int unsigned WAIT16    = 1,
   parameter bit          M16_TWICE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-2:0]     req_waddr,
   input  logic                  req_io,
   input  logic                  req_wr,
   input  logic [1:0]            req_be,
   input  logic [BUS_W-1:0]      req_wdata,
   output logic                  busy,
   output logic                  done,
   output logic [BUS_W-1:0]      rd_data,
   output logic                  bale,
   output logic [SA_W-1:0]       sa,
   output logic [ADDR_W-SA_W+2:0] la,
   output logic                  sbhe_n,
   output logic                  aen,
   output logic                  iorc_n,
   output logic                  iowc_n,
   output logic                  mrdc_n,
   output logic                  mwtc_n,
   output logic                  smrdc_n,
   output logic                  smwtc_n,
   output logic [BUS_W-1:0]      sd_out,
   output logic                  sd_oe,
   input  logic [BUS_W-1:0]      sd_in,
   input  logic                  chrdy,
   input  logic                  nows_n,
   input  logic                  io16_n,
   input  logic                  m16_n
);
   localparam int unsigned LA_LO = SA_W - 3;
   localparam int unsigned HALF  = BUS_W / 2;

   generate
      if (ADDR_W <= SA_W)   begin : g_bad_addr  $error("ADDR_W must exceed SA_W"); end
      if (SA_W < 4)         begin : g_bad_sa    $error("SA_W too small");          end
      if (WAIT8 < 1)        begin : g_bad_w8    $error("WAIT8 must be >= 1");      end
      if (WAIT16 < 1)       begin : g_bad_w16   $error("WAIT16 must be >= 1");     end
      if (BUS_W != 16)      begin : g_bad_bus   $error("bus must be 16 bits");     end
   endgenerate

   seq_state_e st_q, st_d;
   logic [ADDR_W-1:1] addr_q;
   logic              io_q, wr_q, hi_q, wide_q, done_q;
   logic [1:0]        be_q;
   logic [BUS_W-1:0]  wd_q, rd_q;

   logic in_addr, in_cmd, in_wait, strobe_on;
   logic ack16, want16, wide_cmd, wide_now, end_now, split_more, low_meg, a0;

   assign in_addr   = (st_q == ST_ADDR);
   assign in_cmd    = (st_q == ST_CMD);
   assign in_wait   = (st_q == ST_WAIT);
   assign strobe_on = in_cmd | in_wait;

   assign want16     = (be_q == 2'b11);
   assign wide_cmd   = want16 & ~hi_q & ack16;
   assign wide_now   = in_cmd ? wide_cmd : wide_q;
   assign split_more = want16 & ~hi_q & ~wide_now;
   assign low_meg    = ~|addr_q[ADDR_W-1:SA_W];
   assign a0         = hi_q | (be_q == 2'b10);

   isa_width_probe #(.M16_TWICE(M16_TWICE)) probe_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_addr (in_addr),
      .in_cmd  (in_cmd),
      .is_io   (io_q),
      .io16_n  (io16_n),
      .m16_n   (m16_n),
      .ack16   (ack16)
   );

   isa_wait_ctrl #(.WAIT8(WAIT8), .WAIT16(WAIT16)) wait_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_cmd  (in_cmd),
      .in_wait (in_wait),
      .wide    (wide_now),
      .is_io   (io_q),
      .chrdy   (chrdy),
      .nows_n  (nows_n),
      .end_now (end_now)
   );

   isa_strobe_dec strobe_i (
      .active  (strobe_on),
      .is_io   (io_q),
      .is_wr   (wr_q),
      .low_meg (low_meg),
      .iorc_n  (iorc_n),
      .iowc_n  (iowc_n),
      .mrdc_n  (mrdc_n),
      .mwtc_n  (mwtc_n),
      .smrdc_n (smrdc_n),
      .smwtc_n (smwtc_n)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (req_valid) st_d = ST_ADDR;
         ST_ADDR: st_d = ST_CMD;
         ST_CMD, ST_WAIT: begin
            if (end_now) st_d = split_more ? ST_ADDR : ST_IDLE;
            else         st_d = ST_WAIT;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         io_q   <= 1'b0;
         wr_q   <= 1'b0;
         hi_q   <= 1'b0;
         wide_q <= 1'b0;
         done_q <= 1'b0;
         be_q   <= 2'b00;
         wd_q   <= '0;
         rd_q   <= '0;
      end else begin
         st_q   <= st_d;
         done_q <= 1'b0;
         if (st_q == ST_IDLE && req_valid) begin
            addr_q <= req_waddr;
            io_q   <= req_io;
            wr_q   <= req_wr;
            be_q   <= norm_be(req_be);
            wd_q   <= req_wdata;
            rd_q   <= '0;
            hi_q   <= 1'b0;
            wide_q <= 1'b0;
         end
         if (in_cmd) wide_q <= wide_cmd;
         if (strobe_on && end_now) begin
            if (!wr_q) begin
               if (wide_now)            rd_q              <= sd_in;
               else if (hi_q)           rd_q[BUS_W-1:HALF] <= sd_in[HALF-1:0];
               else if (be_q == 2'b10)  rd_q[BUS_W-1:HALF] <= sd_in[BUS_W-1:HALF];
               else                     rd_q[HALF-1:0]     <= sd_in[HALF-1:0];
            end
            if (split_more) hi_q   <= 1'b1;
            else            done_q <= 1'b1;
         end
      end
   end

   assign busy    = (st_q != ST_IDLE);
   assign done    = done_q;
   assign rd_data = rd_q;
   assign bale    = in_addr;
   assign sa      = {addr_q[SA_W-1:1], a0};
   assign la      = addr_q[ADDR_W-1:LA_LO];
   assign sbhe_n  = ~(be_q[1] & ~hi_q);
   assign aen     = 1'b0;
   assign sd_oe   = wr_q & strobe_on;
   assign sd_out  = hi_q ? {wd_q[BUS_W-1:HALF], wd_q[BUS_W-1:HALF]} : wd_q;
endmodule

// File: rtl/isa_cycle_seq_chk.sv
`timescale 1ns/1ps
module isa_cycle_seq_chk #(
   parameter int unsigned SA_W = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bale,
   input logic            done,
   input logic            iorc_n,
   input logic            iowc_n,
   input logic            mrdc_n,
   input logic            mwtc_n,
   input logic            smrdc_n,
   input logic            smwtc_n,
   input logic            chrdy,
   input logic            sd_oe,
   input logic            sbhe_n,
   input logic [SA_W-1:0] sa
);
   logic act;
   assign act = ~(iorc_n & iowc_n & mrdc_n & mwtc_n);

   p_bale_one_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bale |=> !bale);
   p_bale_to_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bale |=> act);
   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(act));
   p_chrdy_extend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !chrdy) |=> act);
   p_one_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~iorc_n, ~iowc_n, ~mrdc_n, ~mwtc_n}));
   p_smem_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !smrdc_n |-> !mrdc_n);
   p_smem_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !smwtc_n |-> !mwtc_n);
   p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && $past(act)) |-> ($stable(sa) && $stable(sbhe_n)));
   p_wr_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!iowc_n || !mwtc_n) |-> sd_oe);
   p_rd_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!iorc_n || !mrdc_n) |-> !sd_oe);
endmodule

bind isa_cycle_seq isa_cycle_seq_chk #(.SA_W(SA_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .bale    (bale),
   .done    (done),
   .iorc_n  (iorc_n),
   .iowc_n  (iowc_n),
   .mrdc_n  (mrdc_n),
   .mwtc_n  (mwtc_n),
   .smrdc_n (smrdc_n),
   .smwtc_n (smwtc_n),
   .chrdy   (chrdy),
   .sd_oe   (sd_oe),
   .sbhe_n  (sbhe_n),
   .sa      (sa)
);

// File: tb/isa_cycle_seq_tb.sv
`timescale 1ns/1ps
module isa_cycle_seq_tb_top;
   localparam int unsigned ADDR_W = 24;
   localparam int unsigned SA_W   = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [ADDR_W-2:0] req_waddr = '0;
   logic req_io = 1'b0, req_wr = 1'b0;
   logic [1:0] req_be = 2'b00;
   logic [15:0] req_wdata = '0;
   logic busy, done, bale, sbhe_n, aen;
   logic [15:0] rd_data, sd_out;
   logic [SA_W-1:0] sa;
   logic [ADDR_W-SA_W+2:0] la;
   logic iorc_n, iowc_n, mrdc_n, mwtc_n, smrdc_n, smwtc_n, sd_oe;
   logic [15:0] sd_in = 16'hA5A5;
   logic chrdy = 1'b1, nows_n = 1'b1, io16_n = 1'b1, m16_n = 1'b1;

   always #2.5 clk = ~clk;

   isa_cycle_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_waddr(req_waddr),
      .req_io(req_io), .req_wr(req_wr), .req_be(req_be), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .bale(bale), .sa(sa), .la(la),
      .sbhe_n(sbhe_n), .aen(aen), .iorc_n(iorc_n), .iowc_n(iowc_n),
      .mrdc_n(mrdc_n), .mwtc_n(mwtc_n), .smrdc_n(smrdc_n), .smwtc_n(smwtc_n),
      .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in), .chrdy(chrdy),
      .nows_n(nows_n), .io16_n(io16_n), .m16_n(m16_n)
   );

   int n_chk = 0, n_err = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // slave scenario and monitor state
   int s_ext = 0, s_m16 = 0;
   bit s_nows = 0, s_io16 = 0;
   logic [7:0] s_hi = 8'h00, s_lo = 8'h00;
   logic [ADDR_W-2:0] t_waddr = '0;
   bit t_wr = 0;
   logic [15:0] t_wd = '0;
   int m_bale, m_done, m_aen, m_seq_bad, m_smem_bad, m_wr_bad, cnt;
   int m_len [2];
   logic m_sa0 [2];
   logic m_sbhe [2];
   logic [3:0] m_kind;
   bit prev_bale = 0;

   always @(negedge clk) begin
      automatic bit act = !(iorc_n & iowc_n & mrdc_n & mwtc_n);
      automatic int pre;
      automatic int idx;
      automatic bit low = (t_waddr >> (SA_W - 1)) == 0;
      automatic logic [15:0] data;
      if (bale) begin m_bale++; cnt = 0; end
      if (done) m_done++;
      if (aen) m_aen++;
      if (prev_bale && !act) m_seq_bad++;
      idx = (m_bale >= 2) ? 1 : 0;
      if (act) begin
         m_len[idx]++;
         m_sa0[idx]  = sa[0];
         m_sbhe[idx] = sbhe_n;
         m_kind |= {!iorc_n, !iowc_n, !mrdc_n, !mwtc_n};
         if (smrdc_n != !(low && !mrdc_n) || smwtc_n != !(low && !mwtc_n)) m_smem_bad++;
         if (t_wr && (!sd_oe || sd_out != ((idx == 1) ? {t_wd[15:8], t_wd[15:8]} : t_wd)))
            m_wr_bad++;
      end else if (!smrdc_n || !smwtc_n) m_smem_bad++;
      prev_bale = bale;
      pre = cnt;
      if (act) cnt++;
      chrdy  = !(act && pre < s_ext);
      nows_n = !s_nows;
      io16_n = !(s_io16 && (bale || (act && pre == 0)));
      case (s_m16)
         1: m16_n = !(bale || (act && pre == 0));
         2: m16_n = !(act && pre == 0);
         3: m16_n = !bale;
         default: m16_n = 1'b1;
      endcase
      data  = (sa[0] && sbhe_n) ? {8'h00, s_hi} : {s_hi, s_lo};
      sd_in = (act && pre >= s_ext) ? data : 16'hA5A5;
   end

   function automatic int exp_len(bit wide, bit io, int ext, bit nows);
      if (nows && !(wide && io)) return wide ? ext + 1 : ((ext + 1 > 2) ? ext + 1 : 2);
      return 1 + (wide ? 1 : 4) + ext;
   endfunction

   task automatic txn(input logic [ADDR_W-2:0] wa, input bit io, input bit wr,
                      input logic [1:0] be, input logic [15:0] wd, input int ext,
                      input bit nows, input bit io16, input int m16,
                      input logic [7:0] hi, input logic [7:0] lo);
      logic [1:0] be_e;
      bit want16, claim, wide;
      int nx, t, el;
      logic [15:0] exp_rd;
      logic [3:0] exp_kind;
      string ltag;
      @(posedge clk); #1;
      s_ext = ext; s_nows = nows; s_io16 = io16; s_m16 = m16; s_hi = hi; s_lo = lo;
      t_waddr = wa; t_wr = wr; t_wd = wd;
      m_bale = 0; m_done = 0; m_aen = 0; m_seq_bad = 0; m_smem_bad = 0; m_wr_bad = 0;
      m_len[0] = 0; m_len[1] = 0; m_kind = 4'h0;
      req_valid = 1'b1; req_waddr = wa; req_io = io; req_wr = wr; req_be = be; req_wdata = wd;
      @(posedge clk); #1;
      req_valid = 1'b0;
      t = 0;
      while (!done && t < 300) begin @(posedge clk); #1; t++; end
      chk(done, "R1 done seen", {31'd0, done}, 32'd1);
      be_e   = (be == 2'b00) ? 2'b01 : be;
      want16 = (be_e == 2'b11);
      claim  = want16 && (io ? io16 : (m16 != 0));
      wide   = want16 && claim;
      nx     = (want16 && !claim) ? 2 : 1;
      if (wr)                 exp_rd = 16'h0000;
      else if (want16)        exp_rd = {hi, lo};
      else if (be_e == 2'b01) exp_rd = {8'h00, lo};
      else                    exp_rd = {hi, 8'h00};
      chk(rd_data == exp_rd, "R10 R7 R9 read data", {16'd0, rd_data}, {16'd0, exp_rd});
      @(posedge clk); #1;
      chk(!done, "R1 done one clock", {31'd0, done}, 32'd0);
      chk(m_done == 1, "R1 done count", m_done, 1);
      chk(m_bale == nx, "R8 R9 transfer count", m_bale, nx);
      chk(m_seq_bad == 0, "R1 strobe follows bale", m_seq_bad, 0);
      ltag = nows ? "R4 length" : ((ext > 0) ? "R3 length" : "R2 length");
      el = exp_len(wide, io, ext, nows);
      chk(m_len[0] == el, ltag, m_len[0], el);
      chk(m_sa0[0] == (be_e == 2'b10), "R7 SA0", m_sa0[0], (be_e == 2'b10));
      chk(m_sbhe[0] == !be_e[1], "R7 sbhe_n", m_sbhe[0], !be_e[1]);
      if (nx == 2) begin
         el = exp_len(1'b0, io, ext, nows);
         chk(m_len[1] == el, "R9 second length", m_len[1], el);
         chk(m_sa0[1] == 1'b1 && m_sbhe[1] == 1'b1, "R9 second lanes",
             {m_sa0[1], m_sbhe[1]}, 2'b11);
      end
      exp_kind = io ? (wr ? 4'b0100 : 4'b1000) : (wr ? 4'b0001 : 4'b0010);
      chk(m_kind == exp_kind, "R5 strobe kind", m_kind, exp_kind);
      chk(m_aen == 0, "R5 aen low", m_aen, 0);
      chk(m_smem_bad == 0, "R6 low-meg strobes", m_smem_bad, 0);
      chk(m_wr_bad == 0, "R11 write drive", m_wr_bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk(!busy && !done && !bale, "R1 reset idle", {busy, done, bale}, 3'b000);
      chk({iorc_n, iowc_n, mrdc_n, mwtc_n, smrdc_n, smwtc_n} == 6'h3F, "R5 reset strobes high",
          {iorc_n, iowc_n, mrdc_n, mwtc_n, smrdc_n, smwtc_n}, 6'h3F);
      rst_n = 1'b1;
      chk(!aen && !sd_oe, "R11 reset no drive", {aen, sd_oe}, 2'b00);
      // directed corner cases
      txn(23'h000100, 0, 0, 2'b01, 16'h0,    0, 0, 0, 0, 8'h12, 8'h34); // R2 byte default
      txn(23'h000200, 0, 0, 2'b11, 16'h0,    0, 0, 0, 1, 8'h56, 8'h78); // R2 word memory
      txn(23'h000180, 1, 0, 2'b11, 16'h0,    0, 0, 1, 0, 8'h9A, 8'hBC); // R8 word I/O
      txn(23'h000300, 0, 0, 2'b01, 16'h0,    0, 1, 0, 0, 8'h11, 8'h22); // R4 byte nows
      txn(23'h000300, 0, 1, 2'b11, 16'hBEEF, 0, 1, 0, 1, 8'h00, 8'h00); // R4 word mem nows
      txn(23'h000040, 1, 0, 2'b11, 16'h0,    0, 1, 1, 0, 8'h33, 8'h44); // R4 word I/O nows ignored
      txn(23'h000040, 0, 0, 2'b01, 16'h0,    2, 1, 0, 0, 8'h55, 8'h66); // R3 chrdy over nows
      txn(23'h000400, 0, 0, 2'b11, 16'h0,    1, 0, 0, 2, 8'h77, 8'h88); // R8 late m16
      txn(23'h000400, 0, 0, 2'b11, 16'h0,    0, 0, 0, 3, 8'h99, 8'hAA); // R8 early m16 only
      txn(23'h000400, 0, 0, 2'b11, 16'h0,    0, 0, 1, 0, 8'hAB, 8'hCD); // R8 io16 ignored on mem -> R9
      txn(23'h000020, 1, 0, 2'b11, 16'h0,    0, 0, 0, 1, 8'hEF, 8'h01); // R8 m16 ignored on I/O -> R9
      txn(23'h000021, 1, 1, 2'b11, 16'hC3D4, 1, 0, 0, 0, 8'h00, 8'h00); // R9 split write
      txn(23'h000022, 0, 0, 2'b10, 16'h0,    0, 0, 0, 1, 8'h5A, 8'h6B); // R7 odd byte
      txn(23'h000022, 0, 0, 2'b00, 16'h0,    0, 0, 0, 0, 8'h7C, 8'h8D); // R7 empty enables
      txn(23'h480000, 0, 0, 2'b11, 16'h0,    0, 0, 0, 1, 8'h1E, 8'h2F); // R6 above 1 MB read
      txn(23'h7FFFFF, 0, 1, 2'b01, 16'h00F1, 0, 0, 0, 0, 8'h00, 8'h00); // R6 above 1 MB write
      txn(23'h07FFFF, 0, 1, 2'b11, 16'h1234, 3, 0, 0, 1, 8'h00, 8'h00); // R6 R3 top of low meg
      // constrained random
      for (int i = 0; i < 200; i++) begin
         automatic logic [ADDR_W-2:0] wa = ($urandom % 2) ? 23'($urandom % 32'h80000) : 23'($urandom);
         txn(wa, 1'($urandom), 1'($urandom), 2'($urandom), 16'($urandom),
             int'($urandom % 4), 1'(($urandom % 3) == 0), 1'($urandom),
             int'($urandom % 4), 8'($urandom), 8'($urandom));
      end
      repeat (4) @(posedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule